// File: doc/BRIEF.md
# Hashed Page Table Walker

This block turns a 32-bit effective address into a real address when block translation has missed, by searching a hashed page table held in memory. It first picks one of sixteen segment registers from the top nibble of the address, then derives a hash from that segment's virtual segment identifier and the page index. From the hash it locates a 64-byte group of eight two-word entries and reads them in order. When the primary group holds no match, the walker searches the secondary group, which is addressed by the complemented hash.

When an entry matches, the walker passes the entry's second word and the segment value to an external evaluator, which returns read, write and execute grants. A permitted hit sets the referenced bit, and also the changed bit for a store. The second word is written back to memory only when one of those bits actually changes. The result reports the real address and the grants. On a load or fetch the write grant is removed, so that a later store walks the table again and can mark the page changed.

A register port loads the segment registers. The table base and mask are plain inputs, and memory is reached through a simple request port whose read data comes back with a valid strobe.

Top module: `hpw_walker`

## Requirements
- R1: A request is accepted when `reqValid` is high and `busy` is low. The segment register indexed by `reqEa[31:28]` is captured at acceptance, and its bits 23:0 form the segment identifier. A segment write in the same cycle as an acceptance affects only later requests.
- R2: With page index P = `reqEa[27:12]` and H = segment identifier bits 18:0 XOR P, the primary group address is `tblBase | ((H << 6) & tblMask)` and the secondary group address uses ~H (19 bits). Entry i lies at group + 8*i. Its first word sits at offset 0 and its second word at offset 4.
- R3: An entry's first word matches when bit 31 (valid) is 1, bit 6 (hash select) equals the pass (0 primary, 1 secondary), bits 30:7 equal the segment identifier, and bits 5:0 equal P[15:10]. The second word is read only after a match.
- R4: The search order is primary slots 0 to 7, then secondary slots 0 to 7, and the first match ends the search.
- R5: If no entry matches after 16 first-word reads, the walk ends with `doneMiss` and writes nothing.
- R6: The access kind codes are 0 load (needs grant bit 0, read), 1 store (needs bit 1, write) and 2 fetch (needs bit 2, execute). If the needed grant is missing, the walk ends with `doneDeny` and writes nothing.
- R7: On a permitted hit, the walker sets second-word bit 8 (referenced), and on a store also bit 7 (changed). It writes the second word back once, to the entry's offset 4, only if its value changed.
- R8: On a hit, `grant` equals the evaluator grant, with bit 1 forced to 0 unless the access is a store.
- R9: On a hit, `realAddr` is the second word's bits 31:12 concatenated with `reqEa[11:0]`.
- R10: `busy` is high from the cycle after acceptance through the single cycle in which `done` pulses. In that cycle exactly one of `doneHit`, `doneMiss` and `doneDeny` is high. After reset `busy`, `done` and `memReq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request |
| reqEa | input | 32 | Effective address |
| reqKind | input | 2 | 0 load, 1 store, 2 fetch |
| segWe | input | 1 | Segment register write enable |
| segIdx | input | 4 | Segment register index |
| segData | input | 32 | Segment register write data |
| tblBase | input | 32 | Page table base address |
| tblMask | input | 32 | Page table offset mask |
| memReq | output | 1 | Memory access strobe |
| memWe | output | 1 | Memory write (1) or read (0) |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memRdValid | input | 1 | Read data valid |
| memRdata | input | 32 | Read data |
| evalSeg | output | 32 | Captured segment value for the evaluator |
| evalWord1 | output | 32 | Matched entry second word for the evaluator |
| evalGrant | input | 3 | Evaluator grants: bit0 read, bit1 write, bit2 execute |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| doneHit | output | 1 | Completion with translation |
| doneMiss | output | 1 | Completion, no entry found |
| doneDeny | output | 1 | Completion, permission refused |
| realAddr | output | 32 | Translated real address |
| grant | output | 3 | Granted rights for the hit |

## Verification
A segment register write can land in the same cycle as the acceptance of a request that selects that segment. The bench provokes this by raising `segWe` and `reqValid` together, with a new identifier for the requested segment. It judges the outcome by placing a table entry only for the old identifier: the first walk must hit with the old entry's page number, and a repeat of the same request must miss because it now uses the new identifier.

// File: rtl/hpw_pkg.sv
package hpw_pkg;
  localparam int ADDR_W    = 32;
  localparam int SEG_CNT   = 16;
  localparam int SLOTS     = 8;
  localparam int SLOT_W    = $clog2(SLOTS);
  localparam int VSID_W    = 24;
  localparam int HASH_W    = 19;
  localparam int PG_W      = 16;
  localparam int API_W     = 6;
  localparam int ENTRY_SH  = 3;                 // 8-byte entries
  localparam int GROUP_SH  = ENTRY_SH + SLOT_W; // 64-byte groups
  localparam int REF_BIT   = 8;
  localparam int CHG_BIT   = 7;

  typedef enum logic [1:0] {KIND_LOAD = 2'd0, KIND_STORE = 2'd1, KIND_FETCH = 2'd2} kind_e;

  typedef struct packed {
    logic accept;
    logic rdW0;
    logic rdW1;
    logic stepEntry;
    logic startSecond;
    logic capW1;
    logic wrW1;
    logic finHit;
    logic finMiss;
    logic finDeny;
  } ctl_t;
endpackage

// File: rtl/hpw_datapath.sv
module hpw_datapath
  import hpw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic [ADDR_W-1:0] reqEa,
  input  logic [1:0]        reqKind,
  input  logic              segWe,
  input  logic [3:0]        segIdx,
  input  logic [31:0]       segData,
  input  logic [ADDR_W-1:0] tblBase,
  input  logic [ADDR_W-1:0] tblMask,
  input  logic [31:0]       memRdata,
  input  logic [2:0]        evalGrant,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [31:0]       evalSeg,
  output logic [31:0]       evalWord1,
  output logic              match,
  output logic              lastSlot,
  output logic              secondPass,
  output logic              permitted,
  output logic              needWb,
  output logic              doneHit,
  output logic              doneMiss,
  output logic              doneDeny,
  output logic [ADDR_W-1:0] realAddr,
  output logic [2:0]        grant
);
  logic [31:0]       segRegs [SEG_CNT];
  logic [ADDR_W-1:0] eaQ;
  logic [1:0]        kindQ;
  logic [31:0]       segQ;
  logic              passQ;
  logic [SLOT_W-1:0] slotQ;
  logic [31:0]       w1Q;

  logic [VSID_W-1:0] vsid;
  logic [PG_W-1:0]   pageIdx;
  logic [HASH_W-1:0] hashVal;
  logic [ADDR_W-1:0] groupAddr;
  logic [ADDR_W-1:0] entryAddr;
  logic [2:0]        needMask;
  logic [31:0]       newW1;
  logic              isStore;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SEG_CNT; i++) segRegs[i] <= '0;
    end else if (segWe) begin
      segRegs[segIdx] <= segData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eaQ <= '0; kindQ <= '0; segQ <= '0; passQ <= 1'b0; slotQ <= '0; w1Q <= '0;
    end else begin
      if (ctl.accept) begin
        eaQ   <= reqEa;
        kindQ <= reqKind;
        segQ  <= segRegs[reqEa[31:28]];
        passQ <= 1'b0;
        slotQ <= '0;
      end
      if (ctl.stepEntry) slotQ <= slotQ + 1'b1;
      if (ctl.startSecond) begin
        passQ <= 1'b1;
        slotQ <= '0;
      end
      if (ctl.capW1) w1Q <= memRdata;
    end
  end

  assign vsid      = segQ[VSID_W-1:0];
  assign pageIdx   = eaQ[27:12];
  assign hashVal   = (vsid[HASH_W-1:0] ^ HASH_W'(pageIdx)) ^ {HASH_W{passQ}};
  assign groupAddr = tblBase | ((ADDR_W'(hashVal) << GROUP_SH) & tblMask);
  assign entryAddr = groupAddr + ADDR_W'({slotQ, {ENTRY_SH{1'b0}}});
  assign memAddr   = (ctl.rdW1 || ctl.wrW1) ? entryAddr + ADDR_W'(4) : entryAddr;

  assign match = memRdata[31] && (memRdata[6] == passQ) &&
                 (memRdata[30:7] == vsid) && (memRdata[API_W-1:0] == pageIdx[PG_W-1 -: API_W]);
  assign lastSlot   = (slotQ == SLOT_W'(SLOTS - 1));
  assign secondPass = passQ;

  assign isStore = (kindQ == KIND_STORE);
  always_comb begin
    case (kindQ)
      KIND_STORE: needMask = 3'b010;
      KIND_FETCH: needMask = 3'b100;
      default:    needMask = 3'b001;
    endcase
  end
  assign permitted = ((needMask & ~evalGrant) == 3'b000);
  assign newW1     = w1Q | (32'd1 << REF_BIT) | (isStore ? (32'd1 << CHG_BIT) : 32'd0);
  assign needWb    = (newW1 != w1Q);
  assign memWdata  = newW1;
  assign evalSeg   = segQ;
  assign evalWord1 = w1Q;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneHit <= 1'b0; doneMiss <= 1'b0; doneDeny <= 1'b0; realAddr <= '0; grant <= '0;
    end else if (ctl.finHit || ctl.finMiss || ctl.finDeny) begin
      doneHit  <= ctl.finHit;
      doneMiss <= ctl.finMiss;
      doneDeny <= ctl.finDeny;
      realAddr <= ctl.finHit ? {w1Q[31:12], eaQ[11:0]} : '0;
      grant    <= ctl.finHit ? (evalGrant & {1'b1, isStore, 1'b1}) : 3'b000;
    end
  end
endmodule

// File: rtl/hpw_control.sv
module hpw_control
  import hpw_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic memRdValid,
  input  logic match,
  input  logic lastSlot,
  input  logic secondPass,
  input  logic permitted,
  input  logic needWb,
  output ctl_t ctl,
  output logic memReq,
  output logic memWe,
  output logic busy,
  output logic done
);
  typedef enum logic [2:0] {S_IDLE, S_RD0, S_WT0, S_RD1, S_WT1, S_CHK, S_WB, S_FIN} state_e;
  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctl = '0;
    nextState = state;
    case (state)
      S_IDLE: if (reqValid) begin ctl.accept = 1'b1; nextState = S_RD0; end
      S_RD0: begin ctl.rdW0 = 1'b1; nextState = S_WT0; end
      S_WT0: if (memRdValid) begin
        if (match) nextState = S_RD1;
        else if (!lastSlot) begin ctl.stepEntry = 1'b1; nextState = S_RD0; end
        else if (!secondPass) begin ctl.startSecond = 1'b1; nextState = S_RD0; end
        else begin ctl.finMiss = 1'b1; nextState = S_FIN; end
      end
      S_RD1: begin ctl.rdW1 = 1'b1; nextState = S_WT1; end
      S_WT1: if (memRdValid) begin ctl.capW1 = 1'b1; nextState = S_CHK; end
      S_CHK:
        if (!permitted) begin ctl.finDeny = 1'b1; nextState = S_FIN; end
        else if (needWb) nextState = S_WB;
        else begin ctl.finHit = 1'b1; nextState = S_FIN; end
      S_WB: begin ctl.wrW1 = 1'b1; ctl.finHit = 1'b1; nextState = S_FIN; end
      S_FIN: nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign memReq = ctl.rdW0 | ctl.rdW1 | ctl.wrW1;
  assign memWe  = ctl.wrW1;
  assign busy   = (state != S_IDLE);
  assign done   = (state == S_FIN);
endmodule

// File: rtl/hpw_walker.sv
module hpw_walker
  import hpw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [31:0] reqEa,
  input  logic [1:0]  reqKind,
  input  logic        segWe,
  input  logic [3:0]  segIdx,
  input  logic [31:0] segData,
  input  logic [31:0] tblBase,
  input  logic [31:0] tblMask,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  input  logic        memRdValid,
  input  logic [31:0] memRdata,
  output logic [31:0] evalSeg,
  output logic [31:0] evalWord1,
  input  logic [2:0]  evalGrant,
  output logic        busy,
  output logic        done,
  output logic        doneHit,
  output logic        doneMiss,
  output logic        doneDeny,
  output logic [31:0] realAddr,
  output logic [2:0]  grant
);
  ctl_t ctl;
  logic match, lastSlot, secondPass, permitted, needWb;

  hpw_control u_control (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memRdValid(memRdValid),
    .match(match), .lastSlot(lastSlot), .secondPass(secondPass),
    .permitted(permitted), .needWb(needWb), .ctl(ctl),
    .memReq(memReq), .memWe(memWe), .busy(busy), .done(done)
  );

  hpw_datapath u_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqEa(reqEa), .reqKind(reqKind),
    .segWe(segWe), .segIdx(segIdx), .segData(segData),
    .tblBase(tblBase), .tblMask(tblMask), .memRdata(memRdata), .evalGrant(evalGrant),
    .memAddr(memAddr), .memWdata(memWdata), .evalSeg(evalSeg), .evalWord1(evalWord1),
    .match(match), .lastSlot(lastSlot), .secondPass(secondPass),
    .permitted(permitted), .needWb(needWb),
    .doneHit(doneHit), .doneMiss(doneMiss), .doneDeny(doneDeny),
    .realAddr(realAddr), .grant(grant)
  );
endmodule

// File: rtl/hpw_checker.sv
module hpw_checker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [31:0] reqEa,
  input logic [1:0]  reqKind,
  input logic        memReq,
  input logic        memWe,
  input logic        busy,
  input logic        done,
  input logic        doneHit,
  input logic        doneMiss,
  input logic        doneDeny,
  input logic [31:0] realAddr,
  input logic [2:0]  grant
);
  logic [31:0] eaSeen;
  logic [1:0]  kindSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eaSeen <= '0; kindSeen <= '0;
    end else if (reqValid && !busy) begin
      eaSeen <= reqEa; kindSeen <= reqKind;
    end
  end

  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN) done |-> busy); // R10
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $countones({doneHit, doneMiss, doneDeny}) == 1); // R10
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN) !busy |-> !memReq); // R10
  AST_WRITE_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |=> (done && doneHit)); // R7
  AST_WRITE_WITHHELD: assert property (@(posedge clk) disable iff (!rstN)
    (done && doneHit && kindSeen != 2'd1) |-> !grant[1]); // R8
  AST_PAGE_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    (done && doneHit) |-> realAddr[11:0] == eaSeen[11:0]); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R10
endmodule

bind hpw_walker hpw_checker u_checker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqEa(reqEa), .reqKind(reqKind),
  .memReq(memReq), .memWe(memWe), .busy(busy), .done(done),
  .doneHit(doneHit), .doneMiss(doneMiss), .doneDeny(doneDeny),
  .realAddr(realAddr), .grant(grant)
);

// File: tb/hpw_walker_bench.sv
module hpw_walker_bench;
  localparam logic [31:0] BASE = 32'h0000_4000;
  localparam logic [31:0] MASK = 32'h0000_0FC0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [31:0] reqEa = '0;
  logic [1:0] reqKind = '0;
  logic segWe = 1'b0;
  logic [3:0] segIdx = '0;
  logic [31:0] segData = '0;
  logic memReq, memWe, memRdValid;
  logic [31:0] memAddr, memWdata, memRdata, evalSeg, evalWord1, realAddr;
  logic [2:0] evalGrant, grant;
  logic busy, done, doneHit, doneMiss, doneDeny;

  int checks = 0;
  int fails = 0;
  int readCnt = 0;
  int writeCnt = 0;
  logic [31:0] mem [0:8191];
  logic pend = 1'b0;
  logic [31:0] pendAddr = '0;

  always #4 clk = ~clk;

  hpw_walker u_hpw_walker (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqEa(reqEa), .reqKind(reqKind),
    .segWe(segWe), .segIdx(segIdx), .segData(segData), .tblBase(BASE), .tblMask(MASK),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdValid(memRdValid), .memRdata(memRdata), .evalSeg(evalSeg), .evalWord1(evalWord1),
    .evalGrant(evalGrant), .busy(busy), .done(done), .doneHit(doneHit), .doneMiss(doneMiss),
    .doneDeny(doneDeny), .realAddr(realAddr), .grant(grant)
  );

  // evaluator model: read if pp!=0, write if pp==2, execute unless segment bit 28
  assign evalGrant = {~evalSeg[28], evalWord1[1:0] == 2'd2, evalWord1[1:0] != 2'd0};

  // memory model: read data returns two edges after the request
  always @(posedge clk) begin
    memRdValid <= 1'b0;
    if (pend) begin
      memRdValid <= 1'b1;
      memRdata <= mem[pendAddr[14:2]];
      pend <= 1'b0;
    end
    if (memReq && memWe) begin
      mem[memAddr[14:2]] <= memWdata;
      writeCnt <= writeCnt + 1;
    end else if (memReq) begin
      pend <= 1'b1;
      pendAddr <= memAddr;
      readCnt <= readCnt + 1;
    end
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run hung (actual running, expected finished)");
    finishRun();
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] grpAddr(input logic [31:0] seg, input logic [31:0] ea, input bit sec);
    logic [18:0] h;
    h = seg[18:0] ^ {3'b000, ea[27:12]};
    if (sec) h = ~h;
    return BASE | (({13'd0, h} << 6) & MASK);
  endfunction

  function automatic logic [31:0] mkW0(input logic [31:0] seg, input logic [31:0] ea, input bit sec);
    return {1'b1, seg[23:0], sec, ea[27:22]};
  endfunction

  task automatic clearMem();
    for (int i = 0; i < 8192; i++) mem[i] = '0;
  endtask

  task automatic putEntry(input logic [31:0] grp, input int slot, input logic [31:0] w0, input logic [31:0] w1);
    logic [31:0] a;
    a = grp + 32'(slot * 8);
    mem[a[14:2]] = w0;
    mem[a[14:2] + 13'd1] = w1;
  endtask

  function automatic logic [31:0] getW1(input logic [31:0] grp, input int slot);
    logic [31:0] a;
    a = grp + 32'(slot * 8) + 32'd4;
    return mem[a[14:2]];
  endfunction

  task automatic writeSeg(input logic [3:0] idx, input logic [31:0] val);
    @(negedge clk);
    segWe = 1'b1; segIdx = idx; segData = val;
    @(negedge clk);
    segWe = 1'b0;
  endtask

  logic rHit, rMiss, rDeny;
  logic [31:0] rAddr;
  logic [2:0] rGrant;
  int rReads, rWrites;

  task automatic walk(input logic [31:0] ea, input logic [1:0] kind);
    int r0, w0;
    @(negedge clk);
    r0 = readCnt; w0 = writeCnt;
    reqValid = 1'b1; reqEa = ea; reqKind = kind;
    @(negedge clk);
    reqValid = 1'b0;
    while (!done) @(negedge clk);
    rHit = doneHit; rMiss = doneMiss; rDeny = doneDeny; rAddr = realAddr; rGrant = grant;
    check(busy, "R10 busy in done cycle", 32'(busy), 1);
    @(negedge clk);
    rReads = readCnt - r0; rWrites = writeCnt - w0;
    check(!busy && !done, "R10 idle after done", {busy, done}, 0);
  endtask

  localparam logic [31:0] SEG1 = 32'h0001_2345;

  task automatic testReset();
    check(!busy && !done && !memReq, "R10 reset state", {busy, done, memReq}, 0);
  endtask

  task automatic testPrimaryLoad();
    logic [31:0] ea = 32'h1ABC_D123;
    logic [31:0] g;
    clearMem();
    g = grpAddr(SEG1, ea, 0);
    putEntry(g, 0, mkW0(SEG1, ea, 0), 32'h0077_7002);
    walk(ea, 2'd0);
    check(rHit, "R2 primary slot0 hit", 32'(rHit), 1);
    check(rAddr == 32'h0077_7123, "R9 real address", rAddr, 32'h0077_7123);
    check(rGrant == 3'b101, "R8 write withheld on load", 32'(rGrant), 32'h5);
    check(getW1(g, 0) == 32'h0077_7102, "R7 referenced set", getW1(g, 0), 32'h0077_7102);
    check(rReads == 2 && rWrites == 1, "R7 one write-back", rReads * 16 + rWrites, 2 * 16 + 1);
  endtask

  task automatic testMatchRules();
    logic [31:0] ea = 32'h1000_5ABC;
    logic [31:0] g, w;
    clearMem();
    g = grpAddr(SEG1, ea, 0);
    w = mkW0(SEG1, ea, 0);
    putEntry(g, 0, w & 32'h7FFF_FFFF, 32'h0011_1002);  // invalid
    putEntry(g, 1, w | 32'h40, 32'h0022_2002);          // wrong hash select
    putEntry(g, 2, w ^ 32'h1, 32'h0033_3002);           // wrong page bits
    putEntry(g, 3, w, 32'h0044_4002);
    walk(ea, 2'd0);
    check(rHit && rAddr == 32'h0044_4ABC, "R3 match rule picks slot3", rAddr, 32'h0044_4ABC);
    check(rReads == 5, "R3 reads until match", rReads, 5);
  endtask

  task automatic testSecondaryStore();
    logic [31:0] ea = 32'h1234_5678;
    logic [31:0] g;
    clearMem();
    g = grpAddr(SEG1, ea, 1);
    putEntry(g, 5, mkW0(SEG1, ea, 1), 32'h0055_5002);
    walk(ea, 2'd1);
    check(rHit && rAddr == 32'h0055_5678, "R4 secondary slot5 hit", rAddr, 32'h0055_5678);
    check(rReads == 15, "R4 search order reads", rReads, 15);
    check(rGrant == 3'b111, "R8 store keeps write", 32'(rGrant), 32'h7);
    check(getW1(g, 5) == 32'h0055_5182, "R7 referenced and changed set", getW1(g, 5), 32'h0055_5182);
  endtask

  task automatic testPrimaryWins();
    logic [31:0] ea = 32'h1FED_C000;
    clearMem();
    putEntry(grpAddr(SEG1, ea, 1), 0, mkW0(SEG1, ea, 1), 32'h0066_6102);
    putEntry(grpAddr(SEG1, ea, 0), 7, mkW0(SEG1, ea, 0), 32'h0088_8102);
    walk(ea, 2'd0);
    check(rHit && rAddr == 32'h0088_8000, "R4 primary before secondary", rAddr, 32'h0088_8000);
    check(rWrites == 0, "R7 no write when referenced already set", rWrites, 0);
  endtask

  task automatic testNoChangeStore();
    logic [31:0] ea = 32'h1222_2444;
    clearMem();
    putEntry(grpAddr(SEG1, ea, 0), 2, mkW0(SEG1, ea, 0), 32'h0099_9182);
    walk(ea, 2'd1);
    check(rHit && rWrites == 0, "R7 store with both bits set skips write", rWrites, 0);
  endtask

  task automatic testMiss();
    clearMem();
    walk(32'h1333_3000, 2'd0);
    check(rMiss && !rHit && !rDeny, "R5 miss reported", {rHit, rMiss, rDeny}, 3'b010);
    check(rReads == 16 && rWrites == 0, "R5 sixteen reads no write", rReads * 16 + rWrites, 256);
  endtask

  task automatic testDeny();
    logic [31:0] ea = 32'h1444_4010;
    logic [31:0] g;
    clearMem();
    g = grpAddr(SEG1, ea, 0);
    putEntry(g, 1, mkW0(SEG1, ea, 0), 32'h00AA_A000);  // pp 0: no read
    walk(ea, 2'd0);
    check(rDeny && rWrites == 0, "R6 read denied no write", {rDeny, 8'(rWrites)}, 32'h100);
    check(getW1(g, 1) == 32'h00AA_A000, "R6 entry untouched", getW1(g, 1), 32'h00AA_A000);
    writeSeg(4'd1, SEG1 | 32'h1000_0000);  // execute refused for this segment
    putEntry(g, 1, mkW0(SEG1, ea, 0), 32'h00AA_A002);
    walk(ea, 2'd2);
    check(rDeny, "R6 fetch denied", 32'(rDeny), 1);
    writeSeg(4'd1, SEG1);
    walk(ea, 2'd2);
    check(rHit && rGrant == 3'b101, "R6 fetch allowed", 32'(rGrant), 32'h5);
  endtask

  task automatic testSegCollision();
    logic [31:0] ea = 32'h2BBB_B0F0;
    logic [31:0] segA = 32'h0000_0ABC;
    logic [31:0] segB = 32'h0000_0DEF;
    clearMem();
    writeSeg(4'd2, segA);
    putEntry(grpAddr(segA, ea, 0), 0, mkW0(segA, ea, 0), 32'h00CC_C102);
    @(negedge clk);
    reqValid = 1'b1; reqEa = ea; reqKind = 2'd0;
    segWe = 1'b1; segIdx = 4'd2; segData = segB;
    @(negedge clk);
    reqValid = 1'b0; segWe = 1'b0;
    while (!done) @(negedge clk);
    check(doneHit && realAddr == 32'h00CC_C0F0, "R1 old segment used on collision", realAddr, 32'h00CC_C0F0);
    @(negedge clk);
    walk(ea, 2'd0);
    check(rMiss, "R1 new segment used afterwards", 32'(rMiss), 1);
  endtask

  initial begin
    clearMem();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    writeSeg(4'd1, SEG1);
    testPrimaryLoad();
    testMatchRules();
    testSecondaryStore();
    testPrimaryWins();
    testNoChangeStore();
    testMiss();
    testDeny();
    testSegCollision();
    finishRun();
  end
endmodule